// File: doc/BRIEF.md
# Pattern-Triggered Synchronous Serial Receiver

This block deframes a synchronous serial bit stream. Each bit is presented on `rx_bit` with a one-clock `bit_en` strobe that marks one receive-clock sample. While hunting, the block keeps a sliding window of the newest bits. When the newest `sync_len` bits equal the low `sync_len` bits of `start_pat`, that sample is the start event. The block then skips `start_gap` samples and assembles words of `word_len` bits. Each finished word appears right-aligned on `word_data` with a one-clock `word_valid` pulse.

There are two ways a frame can end. In one-shot mode (`run_to_end_pat` = 0), the block stops after `words_per_start` words. It then parks and ignores the line until a `rearm` pulse, which stands in for software writing a fresh start pattern. In continuous mode (`run_to_end_pat` = 1), words keep coming until the newest data bits match `end_pat`, and the block then goes back to hunting. Every frame setting is captured at the start event, so a setting changed during a frame only takes effect at the next start.

Top module: `patsync_rx`

## Requirements
- R1: While reset is held and in the first clock after it, `word_valid` is 0 and `word_data` is 0, and the block is hunting with an empty window.
- R2: A start event occurs on a sample when the newest L = `sync_len` bits (1 to 16) equal `start_pat[L-1:0]`. The newest bit is compared with bit 0 and the bit received L-1 samples earlier with bit L-1, so the pattern goes out on the line from bit L-1 down to bit 0.
- R3: A start event also requires that at least L bits have been sampled since hunting began (after reset, after a rearm, or after a stop match). Bits left over from an earlier frame never count toward a match.
- R4: After a start event, the next `start_gap` samples are ignored, and the sample after them is the first data bit. With a gap of 0, the sample right after the start event is the first data bit.
- R5: A word has N = `word_len` bits (1 to 16). It is presented right-aligned on `word_data`, with `word_valid` high for exactly one clock: the clock after the edge that samples the word's last bit.
- R6: With `msb_first` = 1, the first data bit of a word lands in bit N-1. With `msb_first` = 0, it lands in bit 0 and later bits fill upward.
- R7: In one-shot mode, the block stops after `words_per_start` words (0 is read as 1). It then ignores the line, including any copy of the start pattern, until a `rearm` pulse returns it to hunting.
- R8: In continuous mode, words continue past `words_per_start` until the newest L data bits, all sampled since the first data bit, equal `end_pat[L-1:0]`. That sample ends the frame, the word containing it is discarded even if it is complete, and hunting resumes.
- R9: `sync_len` (for the end match), `end_pat`, `start_gap`, `word_len`, `words_per_start`, `msb_first` and `run_to_end_pat` are captured at the start event. Changing them during a frame does not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One-clock strobe marking a receive sample |
| rx_bit | input | 1 | Serial data bit, valid with `bit_en` |
| sync_len | input | 5 | Pattern length L, 1 to 16 |
| start_pat | input | 16 | Start pattern, low L bits used |
| end_pat | input | 16 | End pattern for continuous mode |
| start_gap | input | 8 | Samples skipped between start event and first data bit |
| word_len | input | 5 | Bits per word, 1 to 16 |
| words_per_start | input | 8 | Words per start event in one-shot mode |
| msb_first | input | 1 | 1: first bit is the word's MSB; 0: first bit is its LSB |
| run_to_end_pat | input | 1 | 0: one-shot mode; 1: continuous until end pattern |
| rearm | input | 1 | One-clock pulse that releases the parked state |
| word_valid | output | 1 | One-clock pulse when a word is complete |
| word_data | output | 16 | Completed word, right-aligned |

## Verification
Every internal fault in this block shows up as a wrong word, a missing word or an extra word within one frame. A window or fill-count error moves the start by one or more samples, so the first word comes out as a shifted bit string on its first `word_valid`. A gap or bit-counter error misaligns every word of the frame. A mode or word-count error shows up only after the last expected word: the block either emits words it should have withheld, or stays silent after a rearm or an end match.

// File: rtl/patsync_rx_pkg.sv
package patsync_rx_pkg;
  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_GAP  = 2'd1,
    ST_DATA = 2'd2,
    ST_PARK = 2'd3
  } rx_state_e;
endpackage

// File: rtl/patsync_rx_window.sv
// Sliding history of sampled bits plus a saturating count of bits seen
// since the last clear.
module patsync_rx_window #(
  parameter int PAT_W  = 16,
  parameter int PLEN_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              clear,
  input  logic              bit_in,
  output logic [PAT_W-1:0]  win,
  output logic [PLEN_W-1:0] fill_now
);
  logic [PAT_W-1:0]  hist;
  logic [PLEN_W-1:0] fill;

  assign win      = {hist[PAT_W-2:0], bit_in};
  assign fill_now = (fill == PLEN_W'(PAT_W)) ? fill : fill + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= '0;
      fill <= '0;
    end else begin
      if (shift_en) hist <= win;
      if (clear) fill <= '0;
      else if (shift_en) fill <= fill_now;
    end
  end

  a_r3_fill_bound: assert property (@(posedge clk) disable iff (rst)
    fill <= PLEN_W'(PAT_W));
endmodule

// File: rtl/patsync_rx_match.sv
// Masked compare of the window against a pattern, gated by fill count.
module patsync_rx_match #(
  parameter int PAT_W  = 16,
  parameter int PLEN_W = 5
) (
  input  logic              check,
  input  logic [PAT_W-1:0]  win,
  input  logic [PLEN_W-1:0] fill_now,
  input  logic [PLEN_W-1:0] len,
  input  logic [PAT_W-1:0]  pat,
  output logic              hit
);
  logic [PLEN_W-1:0] eff_len;
  logic [PAT_W-1:0]  mask;

  always_comb begin
    if (len == '0) eff_len = PLEN_W'(1);
    else if (len > PLEN_W'(PAT_W)) eff_len = PLEN_W'(PAT_W);
    else eff_len = len;
    for (int i = 0; i < PAT_W; i++) mask[i] = (i < int'(eff_len));
  end

  assign hit = check && (fill_now >= eff_len) && (((win ^ pat) & mask) == '0);
endmodule

// File: rtl/patsync_rx_assemble.sv
// Builds one word at a time in either bit order.
module patsync_rx_assemble #(
  parameter int WORD_W = 16,
  parameter int WLEN_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic              abort,
  input  logic              bit_in,
  input  logic              msb_first,
  input  logic [WLEN_W-1:0] len,
  output logic              done,
  output logic [WORD_W-1:0] word
);
  logic [WLEN_W-1:0] cnt;
  logic [WLEN_W-1:0] eff_len;
  logic [WORD_W-1:0] acc;
  logic [WORD_W-1:0] base;
  logic              last;

  always_comb begin
    if (len == '0) eff_len = WLEN_W'(1);
    else if (len > WLEN_W'(WORD_W)) eff_len = WLEN_W'(WORD_W);
    else eff_len = len;
    base = (cnt == '0) ? '0 : acc;
    if (msb_first) word = {base[WORD_W-2:0], bit_in};
    else word = base | (WORD_W'(bit_in) << cnt);
  end

  assign last = (cnt + 1'b1) >= eff_len;
  assign done = take && last;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      acc <= '0;
    end else if (abort) begin
      cnt <= '0;
    end else if (take) begin
      acc <= word;
      cnt <= last ? '0 : cnt + 1'b1;
    end
  end

  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt < WLEN_W'(WORD_W));
endmodule

// File: rtl/patsync_rx.sv
module patsync_rx
  import patsync_rx_pkg::*;
#(
  parameter int PAT_W  = 16,
  parameter int WORD_W = 16,
  parameter int GAP_W  = 8,
  parameter int CNT_W  = 8,
  localparam int PLEN_W = $clog2(PAT_W + 1),
  localparam int WLEN_W = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              rx_bit,
  input  logic [PLEN_W-1:0] sync_len,
  input  logic [PAT_W-1:0]  start_pat,
  input  logic [PAT_W-1:0]  end_pat,
  input  logic [GAP_W-1:0]  start_gap,
  input  logic [WLEN_W-1:0] word_len,
  input  logic [CNT_W-1:0]  words_per_start,
  input  logic              msb_first,
  input  logic              run_to_end_pat,
  input  logic              rearm,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_data
);
  rx_state_e st;

  // frame settings captured at the start event
  logic [PLEN_W-1:0] l_len;
  logic [PAT_W-1:0]  l_end_pat;
  logic [WLEN_W-1:0] l_word_len;
  logic [CNT_W-1:0]  l_words;
  logic              l_msb;
  logic              l_run;

  logic [GAP_W-1:0]  gcnt;
  logic [CNT_W-1:0]  wcnt;
  logic [CNT_W-1:0]  eff_words;

  logic [PAT_W-1:0]  win;
  logic [PLEN_W-1:0] fill_now;
  logic              hit_start, hit_end, win_clear;
  logic              take, word_done;
  logic [WORD_W-1:0] word_nxt;

  // fill keeps counting only while hunting or receiving data without an end
  assign win_clear = (st == ST_PARK) ||
                     (bit_en && !((st == ST_HUNT && !hit_start) ||
                                  (st == ST_DATA && !hit_end)));
  assign take      = (st == ST_DATA) && bit_en && !hit_end;
  assign eff_words = (l_words == '0) ? CNT_W'(1) : l_words;

  patsync_rx_window #(.PAT_W(PAT_W), .PLEN_W(PLEN_W)) u_window (
    .clk(clk), .rst(rst), .shift_en(bit_en), .clear(win_clear),
    .bit_in(rx_bit), .win(win), .fill_now(fill_now)
  );

  patsync_rx_match #(.PAT_W(PAT_W), .PLEN_W(PLEN_W)) u_start_match (
    .check(st == ST_HUNT && bit_en), .win(win), .fill_now(fill_now),
    .len(sync_len), .pat(start_pat), .hit(hit_start)
  );

  patsync_rx_match #(.PAT_W(PAT_W), .PLEN_W(PLEN_W)) u_end_match (
    .check(st == ST_DATA && bit_en && l_run), .win(win), .fill_now(fill_now),
    .len(l_len), .pat(l_end_pat), .hit(hit_end)
  );

  patsync_rx_assemble #(.WORD_W(WORD_W), .WLEN_W(WLEN_W)) u_assemble (
    .clk(clk), .rst(rst), .take(take), .abort(hit_end), .bit_in(rx_bit),
    .msb_first(l_msb), .len(l_word_len), .done(word_done), .word(word_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_HUNT;
      l_len      <= '0;
      l_end_pat  <= '0;
      l_word_len <= '0;
      l_words    <= '0;
      l_msb      <= 1'b0;
      l_run      <= 1'b0;
      gcnt       <= '0;
      wcnt       <= '0;
      word_valid <= 1'b0;
      word_data  <= '0;
    end else begin
      word_valid <= 1'b0;
      case (st)
        ST_HUNT: if (hit_start) begin
          l_len      <= sync_len;
          l_end_pat  <= end_pat;
          l_word_len <= word_len;
          l_words    <= words_per_start;
          l_msb      <= msb_first;
          l_run      <= run_to_end_pat;
          wcnt       <= '0;
          gcnt       <= start_gap;
          st         <= (start_gap == '0) ? ST_DATA : ST_GAP;
        end
        ST_GAP: if (bit_en) begin
          gcnt <= gcnt - 1'b1;
          if (gcnt == GAP_W'(1)) st <= ST_DATA;
        end
        ST_DATA: begin
          if (hit_end) begin
            st <= ST_HUNT;
          end else if (word_done) begin
            word_valid <= 1'b1;
            word_data  <= word_nxt;
            if (!l_run) begin
              if ((wcnt + 1'b1) >= eff_words) st <= ST_PARK;
              else wcnt <= wcnt + 1'b1;
            end
          end
        end
        ST_PARK: if (rearm) st <= ST_HUNT;
        default: st <= ST_HUNT;
      endcase
    end
  end

  a_r5_valid_follows_sample: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> ($past(bit_en) && $past(st) == ST_DATA));
  a_r7_park_holds: assert property (@(posedge clk) disable iff (rst)
    (st == ST_PARK && !rearm) |=> st == ST_PARK);
  a_r4_gap_count_live: assert property (@(posedge clk) disable iff (rst)
    (st == ST_GAP) |-> gcnt != '0);
  a_r2_start_on_sample: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HUNT && !bit_en) |=> st == ST_HUNT);
  a_r8_end_only_in_run: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DATA && !l_run && bit_en && !word_done) |=> st == ST_DATA);
endmodule

// File: tb/test_patsync_rx.sv
module test_patsync_rx;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bit_en = 1'b0;
  logic        rx_bit = 1'b0;
  logic [4:0]  sync_len = 5'd4;
  logic [15:0] start_pat = 16'h000B;
  logic [15:0] end_pat = 16'h0;
  logic [7:0]  start_gap = 8'd0;
  logic [4:0]  word_len = 5'd8;
  logic [7:0]  words_per_start = 8'd1;
  logic        msb_first = 1'b1;
  logic        run_to_end_pat = 1'b0;
  logic        rearm = 1'b0;
  logic        word_valid;
  logic [15:0] word_data;

  int total = 0;
  int bad = 0;
  int ngot = 0;
  logic [15:0] got [0:63];

  always #2 clk = ~clk;

  patsync_rx i_patsync_rx (
    .clk(clk), .rst(rst), .bit_en(bit_en), .rx_bit(rx_bit),
    .sync_len(sync_len), .start_pat(start_pat), .end_pat(end_pat),
    .start_gap(start_gap), .word_len(word_len),
    .words_per_start(words_per_start), .msb_first(msb_first),
    .run_to_end_pat(run_to_end_pat), .rearm(rearm),
    .word_valid(word_valid), .word_data(word_data)
  );

  always @(negedge clk) begin
    if (word_valid) begin
      if (ngot < 64) got[ngot] = word_data;
      ngot++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; bit_en = 1'b0; rearm = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    bit_en = 1'b1; rx_bit = b;
    @(negedge clk);
    bit_en = 1'b0;
  endtask

  task automatic send_bits(input logic [15:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic pulse_rearm();
    rearm = 1'b1;
    @(negedge clk);
    rearm = 1'b0;
  endtask

  task automatic setup(input logic [4:0] len, input logic [15:0] sp,
                       input logic [15:0] ep, input logic [7:0] gap,
                       input logic [4:0] wl, input logic [7:0] wn,
                       input logic msb, input logic run);
    sync_len = len; start_pat = sp; end_pat = ep; start_gap = gap;
    word_len = wl; words_per_start = wn; msb_first = msb; run_to_end_pat = run;
  endtask

  task automatic test_reset();
    rst = 1'b1;
    idle(2);
    chk("R1 valid in reset", int'(word_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 valid after reset", int'(word_valid), 0);
    chk("R1 data after reset", int'(word_data), 0);
  endtask

  task automatic test_one_shot();
    int base;
    do_reset();
    setup(5'd4, 16'h000B, 16'h0, 8'd0, 5'd8, 8'd2, 1'b1, 1'b0);
    base = ngot;
    send_bits(16'b001011, 6);
    send_bits(16'hA5, 8);
    send_bits(16'h3C, 8);
    idle(2);
    chk("R7 word count per start", ngot - base, 2);
    chk("R2 first word", int'(got[base]), 'hA5);
    chk("R5 second word", int'(got[base + 1]), 'h3C);
    send_bits(16'h0BFF, 16);
    send_bits(16'h000B, 8);
    idle(2);
    chk("R7 parked ignores line", ngot - base, 2);
    pulse_rearm();
    send_bits(16'hB, 4);
    send_bits(16'h5A, 8);
    idle(2);
    chk("R7 rearm resumes hunt", ngot - base, 3);
    chk("R7 word after rearm", int'(got[base + 2]), 'h5A);
  endtask

  task automatic test_fill_gate();
    int base;
    do_reset();
    setup(5'd4, 16'h000B, 16'h0, 8'd0, 5'd8, 8'd1, 1'b1, 1'b0);
    base = ngot;
    send_bits(16'hB, 4);
    send_bits(16'h05, 8);
    idle(2);
    chk("R3 frame before rearm", int'(got[base]), 'h05);
    pulse_rearm();
    send_bit(1'b1);
    send_bits(16'h0, 12);
    idle(2);
    chk("R3 stale bits do not start", ngot - base, 1);
  endtask

  task automatic test_gap_lsb();
    int base;
    do_reset();
    setup(5'd3, 16'h0006, 16'h0, 8'd3, 5'd5, 8'd1, 1'b0, 1'b0);
    base = ngot;
    send_bits(16'b00110, 5);
    send_bits(16'b111, 3);
    send_bits(16'b10011, 5);
    idle(2);
    chk("R4 one word after gap", ngot - base, 1);
    chk("R6 lsb-first value", int'(got[base]), 'h19);
  endtask

  task automatic test_run_mode();
    int base;
    do_reset();
    setup(5'd4, 16'h000B, 16'h0006, 8'd0, 5'd4, 8'd1, 1'b1, 1'b1);
    base = ngot;
    send_bits(16'hB, 4);
    send_bits(16'h9, 4);
    send_bits(16'hC, 4);
    send_bits(16'h6, 4);
    idle(2);
    chk("R8 words past count, end word dropped", ngot - base, 2);
    chk("R8 word 0", int'(got[base]), 'h9);
    chk("R8 word 1", int'(got[base + 1]), 'hC);
    send_bits(16'h0, 4);
    send_bits(16'hB, 4);
    send_bits(16'h5, 4);
    idle(2);
    chk("R8 hunting after end match", ngot - base, 3);
    chk("R8 word after restart", int'(got[base + 2]), 'h5);
  endtask

  task automatic test_latch();
    int base;
    do_reset();
    setup(5'd4, 16'h000B, 16'h0, 8'd0, 5'd8, 8'd1, 1'b1, 1'b0);
    base = ngot;
    send_bits(16'hB, 4);
    word_len = 5'd4; msb_first = 1'b0; start_gap = 8'd5;
    send_bits(16'hC3, 8);
    idle(2);
    chk("R9 one word with latched length", ngot - base, 1);
    chk("R9 latched order and gap", int'(got[base]), 'hC3);
  endtask

  task automatic test_wide();
    int base;
    do_reset();
    setup(5'd16, 16'hF00D, 16'h0, 8'd0, 5'd16, 8'd1, 1'b1, 1'b0);
    base = ngot;
    send_bits(16'hF00D, 16);
    send_bits(16'hBEEF, 16);
    idle(2);
    chk("R2 16-bit pattern starts frame", ngot - base, 1);
    chk("R5 16-bit word", int'(got[base]), 'hBEEF);
  endtask

  initial begin
    test_reset();
    test_one_shot();
    test_fill_gate();
    test_gap_lsb();
    test_run_mode();
    test_latch();
    test_wide();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule